// File: doc/BRIEF.md
# Pin-Group Level Interrupt Unit

This block watches a group of general-purpose input pins and turns chosen pin levels into interrupts. It has eight interrupt slots. Each slot picks one of sixteen pins through a 4-bit pin index and a 3-bit trigger code. The trigger code makes the slot fire while its pin is high, fire while its pin is low, or stay disabled. The pins first pass through a two-flop synchroniser. When a slot's condition holds, its pending bit latches.

Software programs the unit over a simple register bus. Writes complete in one cycle and reads return data combinationally. Software reads the pending bits ANDed with the mask, and clears pending bits by writing ones to an acknowledge address. A single registered interrupt line is high while any masked slot is pending. The mask register has two extra upper bits that belong to other interrupt sources. The unit stores those bits and drives them out unchanged.

Each slot is a two-state machine:
- SLOT_IDLE goes to SLOT_PEND on the transition *set*, when the condition holds and no acknowledge is written.
- SLOT_PEND goes to SLOT_IDLE on the transition *clear*, when the slot's acknowledge bit is written as one.
- In every other case the slot keeps its state.
- The acknowledge has priority over a new set in the same cycle.

Register addresses on `bus_addr`:

| Address | Contents |
|---|---|
| 0 | Trigger configuration, 24 bits |
| 1 | Pin select, 32 bits |
| 2 | Mask, 10 bits |
| 3 | Acknowledge, write-only, reads 0 |
| 4 | Masked status, read-only |

Top module: `gpi_level_irq`

## Requirements
- R1: After reset the configuration, pin-select, mask and status registers all read zero, `aux_mask_o` is 0 and `irq_o` is low.
- R2: The configuration (bits 23:0), pin-select (bits 31:0) and mask (bits 9:0) registers read back the values last written. Unused upper bits read as zero.
- R3: Slot k watches pin `pins_in[i]`, where i is the pin-select field at bits 4k+3:4k.
- R4: The trigger field of slot k sits at bits 3k+2:3k of the configuration register. Code 1 fires on a high pin and code 2 fires on a low pin. Code 0 and every other code keep the slot from ever becoming pending.
- R5: A pin change that meets a slot's condition shows in the status register after the third rising edge that follows it (two synchroniser edges, then one latch edge). It does not show after the second edge.
- R6: A pending bit stays set after its condition goes away, until that bit is acknowledged.
- R7: Writing the acknowledge address clears each slot whose data bit is 1 at that edge. Slots whose bit is 0 keep their state. If the condition still holds, the bit sets again one edge later.
- R8: Status bit k reads pending[k] AND mask[k]. A masked-off slot keeps its pending state but never reaches status or `irq_o`.
- R9: `irq_o` is the OR of the status bits, registered, so it follows status one edge later.
- R10: Mask bits 9:8 are stored, read back and driven on `aux_mask_o`. They have no effect on any slot, the status or `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, commits on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pins_in | input | 16 | Asynchronous pin levels |
| irq_o | output | 1 | Combined registered interrupt |
| aux_mask_o | output | 2 | Pass-through of mask bits 9:8 |

## Verification
A pin change reaches status on the third rising edge after the bench drives it, and `irq_o` one edge after that. A register or acknowledge write takes effect at the edge that ends the write cycle. The bench drives inputs and samples outputs on falling edges and counts edges explicitly. The latency check looks at status after the second edge, where it expects no change, and after the third edge, where it expects the new value. The re-arm check reads status once right after the acknowledge edge and again one edge later.

// File: rtl/gpi_pkg.sv
package gpi_pkg;
    typedef enum logic [2:0] {
        TRIG_OFF  = 3'd0,
        TRIG_HIGH = 3'd1,
        TRIG_LOW  = 3'd2
    } trig_code_e;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_PEND = 1'b1
    } slot_state_e;

    localparam logic [2:0] ADDR_CFG  = 3'd0;
    localparam logic [2:0] ADDR_SEL  = 3'd1;
    localparam logic [2:0] ADDR_MASK = 3'd2;
    localparam logic [2:0] ADDR_ACK  = 3'd3;
    localparam logic [2:0] ADDR_STAT = 3'd4;
endpackage

// File: rtl/gpi_sync.sv
module gpi_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_in;
            sync_q <= meta_q;
        end
    end

    assign d_out = sync_q;
endmodule

// File: rtl/gpi_slot.sv
module gpi_slot
    import gpi_pkg::*;
#(
    parameter int PINS  = 16,
    parameter int SEL_W = $clog2(PINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PINS-1:0]  pins_sync,
    input  logic [SEL_W-1:0] sel,
    input  logic [2:0]       trig,
    input  logic             ack,
    output logic             pend
);
    slot_state_e state_q, state_d;
    logic        pin_val;
    logic        cond;

    assign pin_val = pins_sync[sel];

    always_comb begin
        case (trig)
            TRIG_HIGH: cond = pin_val;
            TRIG_LOW:  cond = ~pin_val;
            default:   cond = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: if (cond && !ack) state_d = SLOT_PEND;
            SLOT_PEND: if (ack)          state_d = SLOT_IDLE;
        endcase
    end

    assign pend = (state_q == SLOT_PEND);

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !pend);

    assert_latch_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack) |=> pend);

    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && trig != TRIG_HIGH && trig != TRIG_LOW) |=> !pend);
endmodule

// File: rtl/gpi_regs.sv
module gpi_regs
    import gpi_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int SEL_W  = 4,
    parameter int TRIG_W = 3,
    parameter int AUX_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2:0]                bus_addr,
    input  logic                      bus_wr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [SLOTS-1:0]          status,
    output logic [SLOTS*TRIG_W-1:0]   cfg_o,
    output logic [SLOTS*SEL_W-1:0]    sel_o,
    output logic [SLOTS+AUX_W-1:0]    mask_o,
    output logic [SLOTS-1:0]          ack_o
);
    localparam int CFG_W  = SLOTS * TRIG_W;
    localparam int SELT_W = SLOTS * SEL_W;
    localparam int MASK_W = SLOTS + AUX_W;

    logic [CFG_W-1:0]  cfg_q;
    logic [SELT_W-1:0] sel_q;
    logic [MASK_W-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            sel_q  <= '0;
            mask_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_CFG)  cfg_q  <= bus_wdata[CFG_W-1:0];
            if (bus_addr == ADDR_SEL)  sel_q  <= bus_wdata[SELT_W-1:0];
            if (bus_addr == ADDR_MASK) mask_q <= bus_wdata[MASK_W-1:0];
        end
    end

    assign ack_o = (bus_wr && bus_addr == ADDR_ACK) ? bus_wdata[SLOTS-1:0] : '0;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CFG:  bus_rdata = DATA_W'(cfg_q);
            ADDR_SEL:  bus_rdata = DATA_W'(sel_q);
            ADDR_MASK: bus_rdata = DATA_W'(mask_q);
            ADDR_STAT: bus_rdata = DATA_W'(status);
            default:   bus_rdata = '0;
        endcase
    end

    assign cfg_o  = cfg_q;
    assign sel_o  = sel_q;
    assign mask_o = mask_q;

    assert_mask_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_MASK) |=> $stable(mask_q));
endmodule

// File: rtl/gpi_level_irq.sv
module gpi_level_irq
    import gpi_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int PINS   = 16,
    parameter int AUX_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pins_in,
    output logic              irq_o,
    output logic [AUX_W-1:0]  aux_mask_o
);
    localparam int SEL_W  = $clog2(PINS);
    localparam int TRIG_W = 3;
    localparam int MASK_W = SLOTS + AUX_W;

    logic [PINS-1:0]         pins_sync;
    logic [SLOTS*TRIG_W-1:0] cfg;
    logic [SLOTS*SEL_W-1:0]  sel;
    logic [MASK_W-1:0]       mask;
    logic [SLOTS-1:0]        ack;
    logic [SLOTS-1:0]        pend;
    logic [SLOTS-1:0]        status;
    logic                    irq_q;

    gpi_sync #(.W(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pins_in),
        .d_out (pins_sync)
    );

    gpi_regs #(
        .SLOTS(SLOTS), .SEL_W(SEL_W), .TRIG_W(TRIG_W),
        .AUX_W(AUX_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .status    (status),
        .cfg_o     (cfg),
        .sel_o     (sel),
        .mask_o    (mask),
        .ack_o     (ack)
    );

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        gpi_slot #(.PINS(PINS), .SEL_W(SEL_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .pins_sync (pins_sync),
            .sel       (sel[k*SEL_W +: SEL_W]),
            .trig      (cfg[k*TRIG_W +: TRIG_W]),
            .ack       (ack[k]),
            .pend      (pend[k])
        );
    end

    assign status = pend & mask[SLOTS-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |status;
    end

    assign irq_o      = irq_q;
    assign aux_mask_o = mask[MASK_W-1:SLOTS];

    assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|status) |=> irq_o);

    assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|status) |=> !irq_o);

    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask[SLOTS-1:0] == '0) |=> !irq_o);
endmodule

// File: tb/gpi_level_irq_tb_top.sv
`timescale 1ns/1ps
module gpi_level_irq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pins_in = '0;
    logic        irq_o;
    logic [1:0]  aux_mask_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    gpi_level_irq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pins_in    (pins_in),
        .irq_o      (irq_o),
        .aux_mask_o (aux_mask_o)
    );

    // {pins, expected status}
    localparam int NVEC = 6;
    localparam logic [23:0] VEC [NVEC] = '{
        {16'h0000, 8'h8A},
        {16'hFFFF, 8'h45},
        {16'h0001, 8'h89},
        {16'h1020, 8'hCE},
        {16'h8008, 8'h02},
        {16'h0280, 8'h8A}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(3'd0, rd); check("R1 cfg", rd, 32'h0);
        bus_read(3'd1, rd); check("R1 sel", rd, 32'h0);
        bus_read(3'd2, rd); check("R1 mask", rd, 32'h0);
        bus_read(3'd4, rd); check("R1 status", rd, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 aux", {30'b0, aux_mask_o}, 32'h0);

        // R2 readback, R10 aux bits
        bus_write(3'd0, 32'hFFFF_FFFF);
        bus_read(3'd0, rd); check("R2 cfg width", rd, 32'h00FF_FFFF);
        bus_write(3'd2, 32'hFFFF_FFFF);
        bus_read(3'd2, rd); check("R2 mask width", rd, 32'h0000_03FF);
        check("R10 aux out", {30'b0, aux_mask_o}, 32'h3);
        bus_read(3'd3, rd); check("R2 ack reads zero", rd, 32'h0);

        // Slot setup: R3 pin routing, R4 trigger codes
        bus_write(3'd0, {8'h00, 3'd2, 3'd1, 3'd7, 3'd0, 3'd2, 3'd1, 3'd2, 3'd1});
        bus_write(3'd1, 32'h3C97_F500);
        bus_read(3'd1, rd); check("R2 sel", rd, 32'h3C97_F500);
        bus_write(3'd2, 32'h0000_00FF);
        check("R10 aux cleared", {30'b0, aux_mask_o}, 32'h0);

        // Table walk: R3/R4/R7 (ack rearm on held condition)
        for (int i = 0; i < NVEC; i++) begin
            pins_in = VEC[i][23:8];
            repeat (4) @(negedge clk);
            bus_write(3'd3, 32'h0000_00FF);
            @(negedge clk);
            bus_read(3'd4, rd);
            check("R3 R4 vector", rd, {24'h0, VEC[i][7:0]});
        end

        // R5 latency, R9 irq latency, using slot2 (pin5 high) only
        pins_in = 16'h0000;
        bus_write(3'd2, 32'h0000_0004);
        repeat (4) @(negedge clk);
        bus_write(3'd3, 32'h0000_00FF);
        @(negedge clk);
        bus_read(3'd4, rd); check("R5 idle before", rd, 32'h0);
        check("R9 irq idle", {31'b0, irq_o}, 32'h0);
        pins_in = 16'h0020;
        @(negedge clk); @(negedge clk);
        bus_read(3'd4, rd); check("R5 not after two edges", rd, 32'h0);
        @(negedge clk);
        bus_read(3'd4, rd); check("R5 after three edges", rd, 32'h4);
        check("R9 irq not yet", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R9 irq one edge later", {31'b0, irq_o}, 32'h1);

        // R6 latch after condition goes away
        pins_in = 16'h0000;
        repeat (5) @(negedge clk);
        bus_read(3'd4, rd); check("R6 latched", rd, 32'h4);

        // R7 zero bits untouched, one bit clears
        bus_write(3'd3, 32'h0000_00FB);
        bus_read(3'd4, rd); check("R7 zero bit keeps", rd, 32'h4);
        bus_write(3'd3, 32'h0000_0004);
        bus_read(3'd4, rd); check("R7 cleared", rd, 32'h0);
        @(negedge clk);
        bus_read(3'd4, rd); check("R7 stays clear", rd, 32'h0);
        check("R9 irq fell", {31'b0, irq_o}, 32'h0);

        // R7 rearm while condition held
        pins_in = 16'h0020;
        repeat (4) @(negedge clk);
        bus_write(3'd3, 32'h0000_0004);
        bus_read(3'd4, rd); check("R7 clear at ack edge", rd, 32'h0);
        @(negedge clk);
        bus_read(3'd4, rd); check("R7 rearm next edge", rd, 32'h4);

        // R8 masking keeps pending hidden, R10 aux bits have no effect
        bus_write(3'd2, 32'h0000_0300);
        bus_read(3'd4, rd); check("R10 aux no status", rd, 32'h0);
        @(negedge clk);
        check("R8 irq masked", {31'b0, irq_o}, 32'h0);
        pins_in = 16'h0000;
        repeat (4) @(negedge clk);
        bus_write(3'd2, 32'h0000_0004);
        bus_read(3'd4, rd); check("R8 pending kept under mask", rd, 32'h4);
        @(negedge clk);
        check("R8 irq after unmask", {31'b0, irq_o}, 32'h1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule